// File: doc/BRIEF.md
# Dual-Loop PLL Lock Detector

This block watches two frequency synthesizer loops and drives one lock indication. Each loop supplies two pulse trains: its divided reference and its divided oscillator feedback. A fast sampling clock measures the time between matching rising edges of the two trains. When the gap between the edges stays inside a fixed window, measured in sampling-clock cycles, the loop counts as locked. When the gap is wider than the window, or the partner edge does not arrive, the loop counts as unlocked. The window is the same absolute time for both loops. Each loop gets one verdict per reference period, so a loop that compares at a slower rate also reports more slowly.

Each loop runs a small state machine. ST_SLEEP is entered from any state while that loop's power-save input is high. ST_WAIT waits for the first edge of a pair. ST_REF_LEAD counts cycles after a reference edge while waiting for the feedback edge. ST_FB_LEAD counts cycles after a feedback edge while waiting for the reference edge. The machine moves between these states as follows:
- ST_WAIT or ST_SLEEP goes to ST_REF_LEAD on a reference edge alone.
- ST_WAIT or ST_SLEEP goes to ST_FB_LEAD on a feedback edge alone.
- Either lead state returns to ST_WAIT on the partner edge, which gives a verdict from the count.
- Either lead state also returns to ST_WAIT with a fail verdict on a timeout or on a repeat of its own edge.

A loop in power save always reports locked. Its stored state is cleared, so when it wakes it reports unlocked until it has a good comparison. The output pin is the registered AND of the two per-loop indications.

Top module: `pll_lock_detect`

## Requirements
- R1: `lock_out` is registered. After each rising clock edge it equals the AND, over all loops, of the per-loop indications sampled at that edge. A loop's indication is high when the loop is asleep or its stored lock state is set. So one unlocked, awake loop drives `lock_out` low.
- R2: Skew is the number of clock cycles between the sampled rising edge of `ref_pulse[i]` and that of `fb_pulse[i]`, in either order. A pair with a skew of 1 to SKEW_WIN cycles sets loop i locked. The boundary value SKEW_WIN counts as locked.
- R3: A skew greater than SKEW_WIN sets loop i unlocked. So does a missing partner edge. This verdict is given SKEW_WIN+1 cycles after the first edge of the pair.
- R4: Reference and feedback rising edges sampled in the same cycle count as skew 0, and the loop becomes locked.
- R5: A loop's stored lock state changes only at a verdict. With no pulses arriving, it holds its value indefinitely.
- R6: While `sleep[i]` is 1, loop i's indication is high whatever its pulses do. With every bit of `sleep` set, `lock_out` is 1 one cycle later.
- R7: Sleep clears the stored lock state. After `sleep[i]` returns to 0, loop i reports unlocked until its first passing comparison.
- R8: While `rst_n` is 0, `lock_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock used to measure edge skew |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_pulse | input | NUM_LOOPS | Divided reference pulse train, one bit per loop |
| fb_pulse | input | NUM_LOOPS | Divided feedback pulse train, one bit per loop |
| sleep | input | NUM_LOOPS | Power-save control per loop, 1 = asleep |
| lock_out | output | 1 | Combined lock indication, 1 = all loops locked or asleep |

## Verification
The assertions and the state machines assume that the pulse inputs are synchronous to `clk`. They also assume that each pulse is low for at least one cycle between rising edges, and that the reference period is longer than twice SKEW_WIN, so a pair never overlaps the next reference edge. The stimulus generates every pulse train on the falling clock edge. Each pulse is three cycles wide, and the reference periods are 60 and 360 cycles against a window of 10. The skew changes in the middle of a stream, so these limits still hold while the stimulus moves across the window boundary and through missing-edge cases.

// File: rtl/pld_pkg.sv
package pld_pkg;
    typedef enum logic [1:0] {
        ST_SLEEP,
        ST_WAIT,
        ST_REF_LEAD,
        ST_FB_LEAD
    } pld_state_e;
endpackage

// File: rtl/pld_rise_detect.sv
module pld_rise_detect #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sig,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sig;
    end

    assign rise = sig & ~prev_q;
endmodule

// File: rtl/pld_loop_fsm.sv
module pld_loop_fsm
    import pld_pkg::*;
#(
    parameter int SKEW_WIN = 10,
    parameter int CNT_W    = $clog2(SKEW_WIN + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep,
    input  logic ref_rise,
    input  logic fb_rise,
    output logic loop_ok
);
    localparam logic [CNT_W-1:0] WIN_C = CNT_W'(SKEW_WIN);

    pld_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             lock_q;
    logic             verdict_vld;
    logic             verdict_ok;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_WAIT;
            cnt_q   <= '0;
            lock_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (sleep)            lock_q <= 1'b0;
            else if (verdict_vld) lock_q <= verdict_ok;
        end
    end

    // next state and verdict
    always_comb begin
        state_d     = state_q;
        cnt_d       = cnt_q;
        verdict_vld = 1'b0;
        verdict_ok  = 1'b0;
        if (sleep) begin
            state_d = ST_SLEEP;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_SLEEP, ST_WAIT: begin
                    state_d = ST_WAIT;
                    cnt_d   = '0;
                    if (ref_rise && fb_rise) begin
                        verdict_vld = 1'b1;
                        verdict_ok  = 1'b1;
                    end else if (ref_rise) begin
                        state_d = ST_REF_LEAD;
                    end else if (fb_rise) begin
                        state_d = ST_FB_LEAD;
                    end
                end
                ST_REF_LEAD: begin
                    if (fb_rise) begin
                        verdict_vld = 1'b1;
                        verdict_ok  = (cnt_q < WIN_C);
                        state_d     = ST_WAIT;
                    end else if (cnt_q == WIN_C || ref_rise) begin
                        verdict_vld = 1'b1;
                        state_d     = ST_WAIT;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_FB_LEAD: begin
                    if (ref_rise) begin
                        verdict_vld = 1'b1;
                        verdict_ok  = (cnt_q < WIN_C);
                        state_d     = ST_WAIT;
                    end else if (cnt_q == WIN_C || fb_rise) begin
                        verdict_vld = 1'b1;
                        state_d     = ST_WAIT;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            endcase
        end
    end

    assign loop_ok = sleep | lock_q;
endmodule

// File: rtl/pll_lock_detect.sv
module pll_lock_detect #(
    parameter int NUM_LOOPS = 2,
    parameter int SKEW_WIN  = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LOOPS-1:0] ref_pulse,
    input  logic [NUM_LOOPS-1:0] fb_pulse,
    input  logic [NUM_LOOPS-1:0] sleep,
    output logic                 lock_out
);
    localparam int CNT_W = $clog2(SKEW_WIN + 1);

    logic [NUM_LOOPS-1:0] loop_ok;

    for (genvar g = 0; g < NUM_LOOPS; g++) begin : g_loop
        logic [1:0] rise;

        pld_rise_detect #(.W(2)) u_rise (
            .clk   (clk),
            .rst_n (rst_n),
            .sig   ({fb_pulse[g], ref_pulse[g]}),
            .rise  (rise)
        );

        pld_loop_fsm #(.SKEW_WIN(SKEW_WIN), .CNT_W(CNT_W)) u_fsm (
            .clk      (clk),
            .rst_n    (rst_n),
            .sleep    (sleep[g]),
            .ref_rise (rise[0]),
            .fb_rise  (rise[1]),
            .loop_ok  (loop_ok[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lock_out <= 1'b0;
        else        lock_out <= &loop_ok;
    end
endmodule

// File: rtl/pld_checker.sv
module pld_checker #(
    parameter int NUM_LOOPS = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_LOOPS-1:0] sleep,
    input logic [NUM_LOOPS-1:0] loop_ok,
    input logic                 lock_out
);
    // R1
    and_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (lock_out == &$past(loop_ok)));

    // R6
    all_sleep_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&sleep) |=> lock_out);

    for (genvar g = 0; g < NUM_LOOPS; g++) begin : g_chk
        // R7
        wake_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(sleep[g]) |-> !loop_ok[g]);

        // R1
        one_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !loop_ok[g] |=> !lock_out);
    end
endmodule

bind pll_lock_detect pld_checker #(.NUM_LOOPS(NUM_LOOPS)) u_pld_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sleep    (sleep),
    .loop_ok  (loop_ok),
    .lock_out (lock_out)
);

// File: tb/tb_pll_lock_detect.sv
`timescale 1ns/1ps
module tb_pll_lock_detect;
    localparam int NL  = 2;
    localparam int WIN = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NL-1:0] ref_pulse = '0;
    logic [NL-1:0] fb_pulse = '0;
    logic [NL-1:0] sleep = '1;
    logic          lock_out;

    int errors = 0;
    int checks = 0;
    string cur_req = "R8";
    bit started = 0;

    int per  [NL] = '{60, 360};
    int skew [NL] = '{4, 30};
    int run  [NL] = '{0, 0};
    int miss [NL] = '{0, 0};
    int ph   [NL] = '{0, 0};

    // reference model state
    int  cyc_n = 0;
    int  pend_kind [NL];
    int  pend_t [NL];
    bit  m_lock [NL];
    bit  m_pr [NL];
    bit  m_pf [NL];
    bit  exp_out = 0;
    bit  all_ok;

    always #2.5 clk = ~clk;

    pll_lock_detect #(.NUM_LOOPS(NL), .SKEW_WIN(WIN)) dut (
        .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse),
        .fb_pulse(fb_pulse), .sleep(sleep), .lock_out(lock_out)
    );

    // pulse generators
    always @(negedge clk) begin
        for (int i = 0; i < NL; i++) begin
            if (run[i] == 0) begin
                ph[i] = 0;
                ref_pulse[i] = 1'b0;
                fb_pulse[i] = 1'b0;
            end else begin
                ph[i] = (ph[i] + 1) % per[i];
                ref_pulse[i] = (ph[i] < 3);
                fb_pulse[i] = (miss[i] == 0) &&
                    ((((ph[i] - skew[i]) % per[i]) + per[i]) % per[i] < 3);
            end
        end
    end

    // behavioural model from timestamps of sampled rising edges
    always @(posedge clk) begin
        started = 1;
        if (!rst_n) begin
            exp_out = 0;
            for (int i = 0; i < NL; i++) begin
                pend_kind[i] = 0; m_lock[i] = 0; m_pr[i] = 0; m_pf[i] = 0;
            end
        end else begin
            all_ok = 1;
            for (int i = 0; i < NL; i++) all_ok = all_ok & (sleep[i] | m_lock[i]);
            exp_out = all_ok;
            for (int i = 0; i < NL; i++) begin
                bit rr, fr;
                rr = ref_pulse[i] & !m_pr[i];
                fr = fb_pulse[i] & !m_pf[i];
                m_pr[i] = ref_pulse[i];
                m_pf[i] = fb_pulse[i];
                if (sleep[i]) begin
                    m_lock[i] = 0; pend_kind[i] = 0;
                end else if (pend_kind[i] == 0) begin
                    if (rr && fr) m_lock[i] = 1;
                    else if (rr) begin pend_kind[i] = 1; pend_t[i] = cyc_n; end
                    else if (fr) begin pend_kind[i] = 2; pend_t[i] = cyc_n; end
                end else begin
                    bit partner, same;
                    partner = (pend_kind[i] == 1) ? fr : rr;
                    same    = (pend_kind[i] == 1) ? rr : fr;
                    if (partner) begin
                        m_lock[i] = (cyc_n - pend_t[i] <= WIN); pend_kind[i] = 0;
                    end else if (cyc_n - pend_t[i] > WIN || same) begin
                        m_lock[i] = 0; pend_kind[i] = 0;
                    end
                end
            end
            cyc_n++;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (started) begin
            checks++;
            if (lock_out !== exp_out) begin
                errors++;
                $display("FAIL %s cycle compare: lock_out actual=%b expected=%b at %0t",
                         cur_req, lock_out, exp_out, $time);
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic spot(input string req, input bit expv);
        checks++;
        if (lock_out !== expv) begin
            errors++;
            $display("FAIL %s spot: lock_out actual=%b expected=%b", req, lock_out, expv);
        end
    endtask

    initial begin
        cyc(3);
        spot("R8", 1'b0);                       // R8 reset holds output low
        rst_n = 1'b1;
        cur_req = "R6";
        cyc(3);
        spot("R6", 1'b1);                       // R6 both asleep
        run = '{1, 1};
        cyc(400);
        spot("R6", 1'b1);                       // R6 bad skew ignored while asleep
        skew[1] = 0;
        sleep = '0;
        cur_req = "R7";
        cyc(1);
        spot("R7", 1'b0);                       // R7 wake reports unlocked
        cur_req = "R2";
        cyc(800);
        spot("R2", 1'b1);                       // R2 R4 small skews lock
        skew = '{10, -10};
        cyc(800);
        spot("R2", 1'b1);                       // R2 boundary skew both orders
        cur_req = "R3";
        skew[0] = 11;
        cyc(200);
        spot("R3", 1'b0);                       // R3 skew past window, R1 AND
        skew[0] = 3;
        miss[1] = 1;
        cyc(800);
        spot("R3", 1'b0);                       // R3 missing feedback
        miss[1] = 0;
        skew[1] = -11;
        cyc(800);
        spot("R3", 1'b0);                       // R3 feedback leads too far
        cur_req = "R6";
        sleep[1] = 1'b1;
        cyc(3);
        spot("R6", 1'b1);                       // R6 R1 unlocked loop asleep
        cur_req = "R7";
        sleep[1] = 1'b0;
        cyc(800);
        spot("R7", 1'b0);                       // R7 wakes unlocked, skew still bad
        skew[1] = 2;
        cyc(800);
        spot("R1", 1'b1);                       // R1 both locked again
        cur_req = "R4";
        skew = '{0, 0};
        cyc(800);
        spot("R4", 1'b1);                       // R4 coincident edges
        cur_req = "R5";
        run = '{0, 0};
        cyc(2000);
        spot("R5", 1'b1);                       // R5 lock held with no pulses
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R1 watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule